// File: doc/BRIEF.md
# USB SE0 Duration Classifier

This block sits beside a USB receiver and watches the decoded line state while no packet is in flight. When the line drops into SE0 from another state, the block starts counting samples. When the line leaves SE0 it decides what the interval was. A long interval is a bus reset. In low-speed mode, a medium interval is a keep-alive. Anything shorter is ignored. Each outcome appears as a single-cycle pulse.

An SE0 that lasts only one sample is treated as noise on an ordinary line change. In that case the new symbol is handed to start-of-packet detection through the same pulse that every non-SE0 line change in idle produces. A sample-enable strobe sets the time base, and only enabled cycles count as samples. The reset and keep-alive limits are given in nanoseconds and converted to sample counts from the sample rate.

Top module: `usb_se0_classifier`

## Requirements
- R1: While reset is held and on the first cycle after it is released, all three output pulses are low.
- R2: Line symbols are encoded SE0=00, J=01, K=10, SE1=11. An SE0 interval is measured as the number of enabled samples from the sample that entered SE0 to the sample that left it. An interval longer than RESET_NS worth of samples (60 with the defaults) raises `busResetPulse` on the cycle after the leaving sample, in either speed mode.
- R3: With `lowSpeed` high on the leaving sample, an interval longer than KEEPALIVE_NS worth of samples (28 with the defaults) and not longer than the reset limit raises `keepAlivePulse`. With `lowSpeed` low the same interval raises nothing.
- R4: An interval of 2 samples up to the keep-alive limit raises no pulse, and the block returns to idle.
- R5: An interval of exactly one sample raises `sopHandoff` only, as if the line had changed directly to the new symbol.
- R6: While idle, every change of the sampled symbol to a non-SE0 value raises `sopHandoff`. A sample equal to the previous one raises nothing.
- R7: Each pulse lasts one cycle, and at most one of the three pulses is high in any cycle.
- R8: The first enabled sample after reset produces no event and is taken as the previous line state. An SE0 present from reset onward is never timed, so its release gives only `sopHandoff`.
- R9: The duration counter saturates, so an SE0 far longer than the counter range still yields `busResetPulse`.
- R10: Cycles with `sampleEn` low are ignored. They neither count toward a duration nor register a line change, and they raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample strobe, one per line sample |
| lineSym | input | 2 | Decoded line symbol (SE0=00, J=01, K=10, SE1=11) |
| lowSpeed | input | 1 | 1 selects low-speed mode, which enables keep-alive detection |
| busResetPulse | output | 1 | One-cycle pulse: bus reset detected |
| keepAlivePulse | output | 1 | One-cycle pulse: low-speed keep-alive detected |
| sopHandoff | output | 1 | One-cycle pulse: the current symbol goes to start-of-packet detection |

## Verification
The bench sweeps SE0 lengths from 1 to 70 samples in both speed modes, so every boundary of the reset and keep-alive limits is checked from both sides. An off-by-one comparison shows up as a missing or extra pulse exactly at 28/29 or 60/61. A missing speed gate would raise keep-alive in full-speed mode. A one-sample SE0 must come out as a hand-off and not as silence. A 3000-sample SE0 catches a counter that wraps instead of saturating, because the wrapped count falls below the reset limit. Further runs cover sample gaps during which the line toggles to K, and an SE0 held from reset, each of which a wrong design would time as an event.

// File: rtl/usb_se0_pkg.sv
package usb_se0_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } lineSym_t;

  // strobes from control to the duration datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntCtrl_t;
endpackage

// File: rtl/usb_se0_datapath.sv
module usb_se0_datapath
  import usb_se0_pkg::*;
#(
  parameter int unsigned RESET_TICKS = 60,
  parameter int unsigned KA_TICKS    = 28,
  localparam int unsigned CNT_W      = $clog2(RESET_TICKS + 2)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cntCtrl_t ctrl,
  output logic     atReset,
  output logic     atKeepAlive,
  output logic     isGlitch
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RESET_TICKS);
  localparam logic [CNT_W-1:0] KA_LIM  = CNT_W'(KA_TICKS);

  // count holds (samples seen in SE0) - 1 once cleared at entry
  logic [CNT_W-1:0] durCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            durCnt <= '0;
    else if (ctrl.clrCnt)  durCnt <= '0;
    else if (ctrl.incCnt && durCnt != CNT_MAX) durCnt <= durCnt + 1'b1;
  end

  // duration on the leaving sample is durCnt + 1
  assign atReset     = durCnt >= RST_LIM;
  assign atKeepAlive = durCnt >= KA_LIM;
  assign isGlitch    = durCnt == '0;
endmodule

// File: rtl/usb_se0_control.sv
module usb_se0_control
  import usb_se0_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleEn,
  input  logic [1:0] lineSym,
  input  logic       lowSpeed,
  input  logic       atReset,
  input  logic       atKeepAlive,
  input  logic       isGlitch,
  output cntCtrl_t   ctrl,
  output logic       busResetPulse,
  output logic       keepAlivePulse,
  output logic       sopHandoff
);
  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_WAIT_END} state_t;

  state_t     state, stateNext;
  logic [1:0] prevSym, prevNext;
  logic       rstNext, kaNext, hoNext;

  always_comb begin
    stateNext = state;
    prevNext  = prevSym;
    ctrl      = '0;
    rstNext   = 1'b0;
    kaNext    = 1'b0;
    hoNext    = 1'b0;
    if (sampleEn) begin
      prevNext = lineSym;
      case (state)
        ST_INIT: stateNext = ST_IDLE;
        ST_IDLE: begin
          if (lineSym != prevSym) begin
            if (lineSym == SYM_SE0) begin
              ctrl.clrCnt = 1'b1;
              stateNext   = ST_WAIT_END;
            end else begin
              hoNext = 1'b1;
            end
          end
        end
        ST_WAIT_END: begin
          if (lineSym == SYM_SE0) begin
            ctrl.incCnt = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            if (isGlitch)                     hoNext  = 1'b1;
            else if (atReset)                 rstNext = 1'b1;
            else if (lowSpeed && atKeepAlive) kaNext  = 1'b1;
          end
        end
        default: stateNext = ST_INIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_INIT;
      prevSym        <= SYM_J;
      busResetPulse  <= 1'b0;
      keepAlivePulse <= 1'b0;
      sopHandoff     <= 1'b0;
    end else begin
      state          <= stateNext;
      prevSym        <= prevNext;
      busResetPulse  <= rstNext;
      keepAlivePulse <= kaNext;
      sopHandoff     <= hoNext;
    end
  end
endmodule

// File: rtl/usb_se0_classifier.sv
module usb_se0_classifier
  import usb_se0_pkg::*;
#(
  parameter int unsigned SAMPLE_HZ    = 24_000_000,
  parameter int unsigned RESET_NS     = 2500,
  parameter int unsigned KEEPALIVE_NS = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleEn,
  input  logic [1:0] lineSym,
  input  logic       lowSpeed,
  output logic       busResetPulse,
  output logic       keepAlivePulse,
  output logic       sopHandoff
);
  localparam int unsigned KHZ         = SAMPLE_HZ / 1000;
  localparam int unsigned RESET_TICKS = KHZ * RESET_NS / 1_000_000;
  localparam int unsigned KA_TICKS    = KHZ * KEEPALIVE_NS / 1_000_000;

  cntCtrl_t ctrl;
  logic     atReset, atKeepAlive, isGlitch;

  usb_se0_datapath #(
    .RESET_TICKS(RESET_TICKS),
    .KA_TICKS   (KA_TICKS)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .atReset    (atReset),
    .atKeepAlive(atKeepAlive),
    .isGlitch   (isGlitch)
  );

  usb_se0_control u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .sampleEn      (sampleEn),
    .lineSym       (lineSym),
    .lowSpeed      (lowSpeed),
    .atReset       (atReset),
    .atKeepAlive   (atKeepAlive),
    .isGlitch      (isGlitch),
    .ctrl          (ctrl),
    .busResetPulse (busResetPulse),
    .keepAlivePulse(keepAlivePulse),
    .sopHandoff    (sopHandoff)
  );
endmodule

// File: rtl/usb_se0_classifier_chk.sv
module usb_se0_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sampleEn,
  input logic [1:0] lineSym,
  input logic       lowSpeed,
  input logic       busResetPulse,
  input logic       keepAlivePulse,
  input logic       sopHandoff
);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busResetPulse, keepAlivePulse, sopHandoff}));

  assert_reset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busResetPulse |=> !busResetPulse);

  assert_ka_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    keepAlivePulse |=> !keepAlivePulse);

  assert_ka_lowspeed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    keepAlivePulse |-> $past(lowSpeed));

  assert_event_leaves_se0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busResetPulse || keepAlivePulse || sopHandoff) |-> $past(lineSym) != 2'b00);

  assert_idle_without_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleEn |=> !(busResetPulse || keepAlivePulse || sopHandoff));
endmodule

bind usb_se0_classifier usb_se0_classifier_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sampleEn      (sampleEn),
  .lineSym       (lineSym),
  .lowSpeed      (lowSpeed),
  .busResetPulse (busResetPulse),
  .keepAlivePulse(keepAlivePulse),
  .sopHandoff    (sopHandoff)
);

// File: tb/sim_usb_se0_classifier.sv
module sim_usb_se0_classifier;
  localparam int RST_T = 60;  // 24 MHz * 2.5 us
  localparam int KA_T  = 28;  // floor(24 MHz * 1.2 us)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sampleEn = 1'b1;
  logic [1:0] lineSym = 2'b01;
  logic       lowSpeed = 1'b0;
  logic       busResetPulse, keepAlivePulse, sopHandoff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit stray;

  always #4 clk = ~clk;

  usb_se0_classifier u0 (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .lineSym(lineSym),
    .lowSpeed(lowSpeed), .busResetPulse(busResetPulse),
    .keepAlivePulse(keepAlivePulse), .sopHandoff(sopHandoff)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {reset,ka,handoff} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {busResetPulse, keepAlivePulse, sopHandoff};
  endfunction

  // drive one cycle at negedge, observe at following negedge
  task automatic step(input logic [1:0] s, input logic en);
    lineSym  = s;
    sampleEn = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runSe0(input int d, input logic ls, input bit gaps);
    logic [2:0] exp;
    lowSpeed = ls;
    step(2'b01, 1'b1);
    step(2'b01, 1'b1);
    stray = 1'b0;
    for (int i = 0; i < d; i++) begin
      step(2'b00, 1'b1);
      if (outs() != 3'b000) stray = 1'b1;
      if (gaps) begin
        step(2'b10, 1'b0);  // R10: toggled line while not sampling
        if (outs() != 3'b000) stray = 1'b1;
      end
    end
    chk("R10 no pulse inside SE0", {2'b00, stray}, 3'b000);
    step(2'b01, 1'b1);
    exp[2] = d > RST_T;
    exp[1] = ls && d > KA_T && d <= RST_T;
    exp[0] = d == 1;
    if (d == 1)          chk("R5 one-sample SE0", outs(), exp);
    else if (d > RST_T)  chk("R2 reset length", outs(), exp);
    else if (d > KA_T)   chk("R3 keep-alive length", outs(), exp);
    else                 chk("R4 short SE0", outs(), exp);
    step(2'b01, 1'b1);
    chk("R7 single-cycle pulse", outs(), 3'b000);
  endtask

  initial begin
    lineSym = 2'b00;  // SE0 present from power-up (R8)
    repeat (3) @(negedge clk);
    chk("R1 during reset", outs(), 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), 3'b000);
    for (int i = 0; i < 100; i++) step(2'b00, 1'b1);
    chk("R8 held SE0 not timed", outs(), 3'b000);
    step(2'b01, 1'b1);
    chk("R8 release gives handoff only", outs(), 3'b001);

    // R6 idle changes
    step(2'b01, 1'b1);
    chk("R6 no change", outs(), 3'b000);
    step(2'b10, 1'b1);
    chk("R6 J to K", outs(), 3'b001);
    step(2'b01, 1'b1);
    chk("R6 K to J", outs(), 3'b001);
    step(2'b11, 1'b1);
    chk("R6 J to SE1", outs(), 3'b001);
    step(2'b01, 1'b1);
    chk("R6 SE1 to J", outs(), 3'b001);

    // sweep across both limits in both modes
    for (int m = 0; m < 2; m++)
      for (int d = 1; d <= 70; d++)
        runSe0(d, m[0], 1'b0);

    // R10: gaps do not count, line toggles in gaps ignored
    runSe0(40, 1'b1, 1'b1);
    runSe0(20, 1'b0, 1'b1);

    // R9: very long SE0 must not wrap
    runSe0(3000, 1'b0, 1'b0);
    runSe0(3000, 1'b1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule